// File: doc/BRIEF.md
# Saturating Scalar Left Shift Unit

This block shifts one scalar element left by an immediate count and clamps the result when it no longer fits. The element width and the shift count both come from one 7-bit immediate. It is split into a 4-bit upper field and a 3-bit lower field. A 2-bit mode picks how the source is read (signed or unsigned) and which range the result is clamped into (signed or unsigned).

Operands enter through a valid/ready handshake and the result appears one cycle later on a registered output, widened with zeros to 128 bits. A sticky flag records that a clamp happened in any completed operation since it was last cleared. An error bit marks reserved encodings, which produce no result data.

Top module: `sat_shl_unit`

## Requirements
- R1: An upper immediate field of 0000, or a mode value of 3, is reserved. That operation returns `out_err`=1 with an all-zero `result`, and it leaves `sat_flag` unchanged.
- R2: The element width is 8, 16, 32 or 64 bits, chosen by whether bit 0, 1, 2 or 3 is the highest set bit of `imm_hi`. The shift count is the unsigned value {imm_hi, imm_lo} minus the element width, so it ranges from 0 to width-1.
- R3: Mode 0 (signed to signed): when the signed result is outside the element's signed range, the output is the most positive value for a non-negative source and the most negative value for a negative source.
- R4: Mode 1 (unsigned to unsigned): when any set bit would leave the element, the output is all ones.
- R5: Mode 2 (signed to unsigned): a negative source gives zero. A non-negative source whose result exceeds the unsigned range gives all ones.
- R6: Result bits above the element width are zero, including all of bits 127 to 64.
- R7: Source bits above the element width have no effect on the result or the flag.
- R8: Every clamp in R3 to R5 sets `sat_flag`. The flag then stays set until `sat_clear` is high at a clock edge. If a clamping operation is accepted in that same edge, the flag stays set.
- R9: `in_ready` is high when the output register is empty or being drained. An operation accepted at one edge is presented at the next. While `out_ready` is low, `result` and `out_err` hold.
- R10: After reset, `out_valid` and `sat_flag` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken |
| imm_hi | input | 4 | Upper immediate field |
| imm_lo | input | 3 | Lower immediate field |
| mode | input | 2 | 0 signed, 1 unsigned, 2 signed to unsigned, 3 reserved |
| src | input | 64 | Source operand; low element-width bits used |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result present |
| result | output | 128 | Element result, zero-extended |
| out_err | output | 1 | Reserved encoding reported |
| sat_clear | input | 1 | Clears the sticky flag |
| sat_flag | output | 1 | Sticky clamp indication |

## Verification
The assertions assume the producer does not raise `in_valid` until a few cycles after reset release, while the internal reset synchroniser is still holding the block. The bench waits out that window before its first operation. The assertions also assume `sat_clear` is a clean level sampled at clock edges, and the bench changes it only one time unit after an edge. The operands, including the reserved encodings, come from the full input space.

// File: rtl/qshl_pkg.sv
package qshl_pkg;
  localparam int HI_W     = 4;
  localparam int LO_W     = 3;
  localparam int IMM_W    = HI_W + LO_W;
  localparam int N_SIZES  = HI_W;
  localparam int SEL_W    = $clog2(N_SIZES);
  localparam int ELEM_MIN = 8;
  localparam int SRC_W    = ELEM_MIN << (N_SIZES - 1);
  localparam int SH_W     = $clog2(SRC_W);

  typedef enum logic [1:0] {
    QS_SS  = 2'd0,
    QS_UU  = 2'd1,
    QS_SU  = 2'd2,
    QS_RSV = 2'd3
  } qs_mode_e;
endpackage

// File: rtl/qshl_rst_sync.sv
module qshl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/qshl_decode.sv
module qshl_decode
  import qshl_pkg::*;
(
  input  logic [HI_W-1:0]  imm_hi,
  input  logic [LO_W-1:0]  imm_lo,
  input  qs_mode_e         mode,
  output logic [SEL_W-1:0] size_sel,
  output logic [SH_W-1:0]  shamt,
  output logic             reserved
);
  logic [IMM_W-1:0] imm_cat;
  logic [IMM_W-1:0] esize;
  logic [IMM_W-1:0] diff;

  // Highest set bit of the upper field selects the element width.
  always_comb begin
    size_sel = '0;
    for (int i = 0; i < HI_W; i++) begin
      if (imm_hi[i]) size_sel = SEL_W'(i);
    end
  end

  always_comb begin
    imm_cat  = {imm_hi, imm_lo};
    esize    = IMM_W'(ELEM_MIN) << size_sel;
    diff     = imm_cat - esize;
    shamt    = diff[SH_W-1:0];
    reserved = (imm_hi == '0) || (mode == QS_RSV);
  end
endmodule

// File: rtl/qshl_lane.sv
module qshl_lane
  import qshl_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]         x,
  input  logic [$clog2(W)-1:0] sh,
  input  qs_mode_e             mode,
  output logic [W-1:0]         y,
  output logic                 sat
);
  localparam int W2 = 2 * W;

  logic          neg;
  logic [W2-1:0] ext;
  logic [W2-1:0] prod;
  logic          ovf_s;
  logic          ovf_u;

  always_comb begin
    neg   = x[W-1] & (mode != QS_UU);
    ext   = {{W{neg}}, x};
    prod  = ext << sh;
    // Signed fit: the top W+1 bits must all equal the sign.
    ovf_s = (prod[W2-1:W-1] != {(W+1){1'b0}}) && (prod[W2-1:W-1] != {(W+1){1'b1}});
    ovf_u = (prod[W2-1:W] != {W{1'b0}});
  end

  always_comb begin
    y   = prod[W-1:0];
    sat = 1'b0;
    unique case (mode)
      QS_SS: begin
        if (ovf_s) begin
          sat = 1'b1;
          y   = neg ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
        end
      end
      QS_UU: begin
        if (ovf_u) begin
          sat = 1'b1;
          y   = {W{1'b1}};
        end
      end
      QS_SU: begin
        if (neg) begin
          sat = 1'b1;
          y   = {W{1'b0}};
        end else if (ovf_u) begin
          sat = 1'b1;
          y   = {W{1'b1}};
        end
      end
      default: begin
        y   = prod[W-1:0];
        sat = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sat_shl_unit.sv
module sat_shl_unit
  import qshl_pkg::*;
#(
  parameter int DST_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [3:0]       imm_hi,
  input  logic [2:0]       imm_lo,
  input  logic [1:0]       mode,
  input  logic [63:0]      src,
  input  logic             out_ready,
  output logic             out_valid,
  output logic [DST_W-1:0] result,
  output logic             out_err,
  input  logic             sat_clear,
  output logic             sat_flag
);
  logic             rst_sync_n;
  qs_mode_e         mode_e;
  logic [SEL_W-1:0] size_sel;
  logic [SH_W-1:0]  shamt;
  logic             reserved;
  logic [SRC_W-1:0] lane_y   [N_SIZES];
  logic             lane_sat [N_SIZES];

  logic             ov_q, ov_n;
  logic             err_q, err_n;
  logic             flag_q, flag_n;
  logic [DST_W-1:0] res_q, res_n;
  logic             accept;
  logic             ld_en;

  assign mode_e = qs_mode_e'(mode);

  qshl_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  qshl_decode u_dec (
    .imm_hi   (imm_hi),
    .imm_lo   (imm_lo),
    .mode     (mode_e),
    .size_sel (size_sel),
    .shamt    (shamt),
    .reserved (reserved)
  );

  for (genvar g = 0; g < N_SIZES; g++) begin : g_lane
    localparam int LW = ELEM_MIN << g;
    logic [LW-1:0] y_g;
    logic          s_g;

    qshl_lane #(.W(LW)) u_lane (
      .x    (src[LW-1:0]),
      .sh   (shamt[$clog2(LW)-1:0]),
      .mode (mode_e),
      .y    (y_g),
      .sat  (s_g)
    );

    assign lane_y[g]   = SRC_W'(y_g);
    assign lane_sat[g] = s_g;
  end

  assign in_ready = rst_sync_n & (~ov_q | out_ready);
  assign accept   = in_valid & in_ready;
  assign ld_en    = accept;

  // Next-state logic.
  always_comb begin
    ov_n   = ov_q;
    err_n  = reserved;
    res_n  = reserved ? '0 : DST_W'(lane_y[size_sel]);
    flag_n = flag_q & ~sat_clear;
    if (accept) begin
      ov_n = 1'b1;
      if (!reserved && lane_sat[size_sel]) flag_n = 1'b1;
    end else if (out_ready) begin
      ov_n = 1'b0;
    end
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ov_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      ov_q   <= ov_n;
      flag_q <= flag_n;
    end
  end

  // Data registers, loaded only on acceptance.
  always_ff @(posedge clk) begin
    if (ld_en) begin
      res_q <= res_n;
      err_q <= err_n;
    end
  end

  assign out_valid = ov_q;
  assign result    = res_q;
  assign out_err   = err_q;
  assign sat_flag  = flag_q;
endmodule

// File: rtl/qshl_chk.sv
module qshl_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_ready,
  input logic         out_valid,
  input logic [127:0] result,
  input logic         out_err,
  input logic         sat_clear,
  input logic         sat_flag
);
  p_err_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> result == '0);

  p_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> result[127:64] == '0);

  p_sticky_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_flag && !sat_clear |=> sat_flag);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clear && !(in_valid && in_ready) |=> !sat_flag);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(out_err));
endmodule

bind sat_shl_unit qshl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .result    (result),
  .out_err   (out_err),
  .sat_clear (sat_clear),
  .sat_flag  (sat_flag)
);

// File: tb/tb_sat_shl_unit.sv
`timescale 1ns/1ps
module tb_sat_shl_unit;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [3:0]   imm_hi;
  logic [2:0]   imm_lo;
  logic [1:0]   mode;
  logic [63:0]  src;
  logic         out_ready;
  logic         out_valid;
  logic [127:0] result;
  logic         out_err;
  logic         sat_clear;
  logic         sat_flag;

  int    checks   = 0;
  int    failures = 0;
  bit    checking = 0;
  bit    stall_on = 0;
  string cur_tag  = "R2";

  // Reference model state, mirrors the output register.
  bit           m_valid;
  logic [127:0] m_res;
  bit           m_err;
  bit           m_flag;
  string        m_tag;
  logic [127:0] t_res;
  bit           t_sat, t_err;

  always #4 clk = ~clk;

  sat_shl_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .imm_hi(imm_hi), .imm_lo(imm_lo), .mode(mode), .src(src),
    .out_ready(out_ready), .out_valid(out_valid), .result(result),
    .out_err(out_err), .sat_clear(sat_clear), .sat_flag(sat_flag)
  );

  function automatic void ref_op(input logic [3:0] h, input logic [2:0] l,
                                 input logic [1:0] md, input logic [63:0] s,
                                 output logic [127:0] r, output bit sat, output bit err);
    int w, sh;
    logic [63:0] mask, m;
    logic signed [129:0] v, p, one, smax, smin, umax;
    err = (h == 4'd0) || (md == 2'd3);
    r = '0;
    sat = 0;
    if (err) return;
    if (h[3]) w = 64; else if (h[2]) w = 32; else if (h[1]) w = 16; else w = 8;
    sh   = int'({h, l}) - w;
    mask = (w == 64) ? {64{1'b1}} : ((64'd1 << w) - 64'd1);
    m    = s & mask;
    one  = 130'sd1;
    v    = $signed({66'd0, m});
    if (md != 2'd1 && m[w-1]) v = v - (one <<< w);
    p    = v <<< sh;
    smax = (one <<< (w - 1)) - one;
    smin = -(one <<< (w - 1));
    umax = (one <<< w) - one;
    if (md == 2'd0) begin
      if (p > smax) begin p = smax; sat = 1; end
      else if (p < smin) begin p = smin; sat = 1; end
    end else begin
      if (p < 0) begin p = 0; sat = 1; end
      else if (p > umax) begin p = umax; sat = 1; end
    end
    r = {64'd0, p[63:0] & mask};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0;
      m_flag  <= 0;
    end else begin
      ref_op(imm_hi, imm_lo, mode, src, t_res, t_sat, t_err);
      if (in_valid && (!m_valid || out_ready)) begin
        m_valid <= 1;
        m_res   <= t_res;
        m_err   <= t_err;
        m_tag   <= cur_tag;
        m_flag  <= (m_flag & ~sat_clear) | (t_sat & ~t_err);
      end else begin
        if (out_ready) m_valid <= 0;
        m_flag <= m_flag & ~sat_clear;
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      chk("R9", "out_valid", 128'(out_valid), 128'(m_valid));
      chk("R9", "in_ready", 128'(in_ready), 128'(!m_valid || out_ready));
      chk("R8", "sat_flag", 128'(sat_flag), 128'(m_flag));
      if (m_valid) begin
        chk(m_tag, "result", result, m_res);
        chk(m_tag, "out_err", 128'(out_err), 128'(m_err));
        chk("R6", "upper half", result[127:64], 128'd0);
      end
    end
  end

  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      out_ready = stall_on ? (($urandom % 3) != 0) : 1'b1;
    end
  end

  task automatic send(input logic [3:0] h, input logic [2:0] l, input logic [1:0] md,
                      input logic [63:0] s, input string tag);
    @(negedge clk);
    imm_hi = h; imm_lo = l; mode = md; src = s; cur_tag = tag;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic clear_flag();
    @(negedge clk);
    sat_clear = 1'b1;
    @(posedge clk);
    #1;
    sat_clear = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; sat_clear = 1'b0;
    imm_hi = '0; imm_lo = '0; mode = '0; src = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R10", "out_valid", 128'(out_valid), 128'd0);
    chk("R10", "sat_flag", 128'(sat_flag), 128'd0);
    chk("R10", "in_ready", 128'(in_ready), 128'd1);
    checking = 1;

    // Size decode and shift count
    send(4'b0001, 3'd3, 2'd1, 64'h05, "R2");
    send(4'b0011, 3'd4, 2'd1, 64'h0123, "R2");
    send(4'b0101, 3'd7, 2'd1, 64'h3, "R2");
    send(4'b1111, 3'd7, 2'd1, 64'h1, "R2");
    send(4'b1000, 3'd0, 2'd0, 64'h8000_0000_0000_0001, "R2");
    // Signed clamp
    send(4'b0001, 3'd3, 2'd0, 64'h10, "R3");
    send(4'b0001, 3'd3, 2'd0, 64'hF0, "R3");
    send(4'b0001, 3'd3, 2'd0, 64'hE0, "R3");
    send(4'b1111, 3'd7, 2'd0, 64'h1, "R3");
    send(4'b0110, 3'd0, 2'd0, 64'hFFFF_FFFF, "R3");
    // Unsigned clamp
    send(4'b0001, 3'd3, 2'd1, 64'h1F, "R4");
    send(4'b0001, 3'd3, 2'd1, 64'h20, "R4");
    send(4'b0010, 3'd0, 2'd1, 64'hFFFF, "R4");
    // Signed to unsigned
    clear_flag();
    send(4'b0001, 3'd3, 2'd2, 64'h10, "R5");
    send(4'b0001, 3'd0, 2'd2, 64'h80, "R5");
    send(4'b0001, 3'd3, 2'd2, 64'h20, "R5");
    // Reserved encodings leave the flag alone
    clear_flag();
    send(4'b0000, 3'd5, 2'd0, 64'hFF, "R1");
    send(4'b0001, 3'd3, 2'd3, 64'hFF, "R1");
    send(4'b0001, 3'd3, 2'd0, 64'h40, "R8");
    send(4'b0000, 3'd1, 2'd1, 64'h1, "R1");
    // Upper source bits ignored
    clear_flag();
    send(4'b0001, 3'd2, 2'd1, 64'hFFFF_FFFF_FFFF_FF03, "R7");
    send(4'b0010, 3'd1, 2'd0, 64'hA5A5_A5A5_A5A5_1234, "R7");
    send(4'b0100, 3'd0, 2'd2, 64'hFFFF_FFFF_7FFF_FFFF, "R7");
    // Stalled consumer
    stall_on = 1;
    for (int i = 0; i < 40; i++)
      send(4'($urandom), 3'($urandom), 2'($urandom), {$urandom, $urandom}, "R9");
    // Mixed traffic
    for (int i = 0; i < 400; i++) begin
      if ((i % 37) == 0) clear_flag();
      send(4'($urandom), 3'($urandom), 2'($urandom), {$urandom, $urandom}, "R3");
    end
    stall_on = 0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule